// File: doc/BRIEF.md
# LIN Master Header Generator

This block produces the header portion of a LIN frame when the node acts as bus master. A start command pulls the serial transmit line low for a break whose length comes from a down-counter that advances on the baud tick. When that counter underflows, the line returns high and a break-complete flag is set. The flag can also raise an interrupt request. After a one-bit delimiter, an internal 8N1 transmitter sends the synch byte 0x55. The identifier byte follows it directly, and then the block goes back to idle.

Software drives plain control pins: a LIN enable, a master select, an interrupt enable, a one-clock start strobe, the break reload value, the identifier byte, a write-one clear for the flag, and an interrupt acknowledge. No byte stream enters or leaves the block, so there is no valid/ready handshake. The identifier is latched when a start is accepted, so later changes on that input do not affect a header already in flight. Bit timing comes from an external single-clock baud tick.

Top module: `lin_hdr_master`

## Requirements
- R1: When start_wr is 1, lin_en and master are both 1, and no header is in progress, tx goes to 0 on the next clock. It then stays 0 for brk_reload+1 baud ticks.
- R2: On the clock after the baud tick where the break counter passes zero, tx returns to 1 and brk_flag becomes 1 on the same edge. tx stays 1 for exactly one tick period as the delimiter.
- R3: If irq_en is 1 on the cycle where the break underflows, irq_req becomes 1 on the next clock. Otherwise the underflow leaves irq_req unchanged.
- R4: After the delimiter, tx sends 0x55 as an 8N1 frame. The frame is a start bit of 0, then eight data bits least significant first, then a stop bit of 1. Each bit lasts one baud tick period.
- R5: The identifier byte latched at start is sent in the same 8N1 format. Its start bit begins on the tick that ends the synch stop bit.
- R6: hdr_done is 1 for exactly one clock, on the clock after the identifier stop bit ends. From that clock on, tx is 1 and the block is idle.
- R7: A start is ignored while lin_en or master is 0. If either drops during a header, the block returns to idle on the next clock: tx goes to 1 and hdr_done is not raised.
- R8: A start_wr while a header is in progress is ignored. The break length and the bytes sent are unchanged.
- R9: flag_clr=1 clears brk_flag on the next clock. irq_ack=1 clears irq_req on the next clock. Each clear acts only on its own output. If a set and a clear arrive in the same cycle, the set wins.
- R10: Synchronous active-high reset gives tx=1, brk_flag=0, irq_req=0 and hdr_done=0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lin_en | input | 1 | LIN function enable |
| master | input | 1 | Master mode select |
| irq_en | input | 1 | Break-complete interrupt enable |
| start_wr | input | 1 | One-clock start strobe |
| brk_reload | input | CNT_W | Break counter reload value N (low time N+1 ticks) |
| id_byte | input | 8 | Identifier byte, latched at start |
| flag_clr | input | 1 | Write-one clear of brk_flag |
| irq_ack | input | 1 | Interrupt acknowledge / software clear |
| baud_tick | input | 1 | One-clock pulse per bit period |
| tx | output | 1 | Serial transmit line |
| brk_flag | output | 1 | Break-complete status flag |
| irq_req | output | 1 | Interrupt request |
| hdr_done | output | 1 | One-clock pulse at end of header |

## Verification
Two cases are hard to reach from the ports. The first is a start strobe arriving while the break counter is still running. The second is an enable dropping in the middle of a header. The bench makes both happen by counting clocks from an accepted start against a fixed four-clock tick spacing. It re-strobes start with a different reload value partway into the break, then checks that the low time still matches the first reload. It clears the master select during a long break and then checks that the line stays high and no done pulse appears. Bit placement is checked by sampling tx on every tick cycle and comparing the whole captured sequence with a frame built from the requirements.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BRK   = 3'd1,
    ST_DELIM = 3'd2,
    ST_SYNC  = 3'd3,
    ST_ID    = 3'd4
  } hdr_state_t;
endpackage

// File: rtl/lin_brk_timer.sv
module lin_brk_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             underflow
);
  logic [CNT_W-1:0] cnt;

  // Underflow is the tick that finds the counter already at zero.
  assign underflow = run && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              tick,
  output logic              txd,
  output logic              last
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [LEFT_W-1:0]  left;

  assign txd  = (left != '0) ? sh[0] : 1'b1;
  assign last = tick && (left == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      sh   <= '1;
      left <= '0;
    end else if (load) begin
      sh   <= {1'b1, data, 1'b0};
      left <= LEFT_W'(FRAME_W);
    end else if (tick && (left != '0)) begin
      sh   <= {1'b1, sh[FRAME_W-1:1]};
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/lin_hdr_master.sv
module lin_hdr_master
  import lin_hdr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lin_en,
  input  logic              master,
  input  logic              irq_en,
  input  logic              start_wr,
  input  logic [CNT_W-1:0]  brk_reload,
  input  logic [BYTE_W-1:0] id_byte,
  input  logic              flag_clr,
  input  logic              irq_ack,
  input  logic              baud_tick,
  output logic              tx,
  output logic              brk_flag,
  output logic              irq_req,
  output logic              hdr_done
);
  hdr_state_t        state;
  logic              active;
  logic              start_ok;
  logic              brk_underflow;
  logic              uart_load;
  logic [BYTE_W-1:0] uart_data;
  logic              uart_txd;
  logic              uart_last;
  logic [BYTE_W-1:0] id_q;

  assign active   = lin_en && master;
  assign start_ok = active && start_wr && (state == ST_IDLE);

  lin_brk_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (start_ok),
    .load_val  (brk_reload),
    .run       (active && (state == ST_BRK)),
    .tick      (baud_tick),
    .underflow (brk_underflow)
  );

  always_comb begin
    uart_load = 1'b0;
    uart_data = SYNC_BYTE;
    if (state == ST_DELIM && baud_tick) begin
      uart_load = 1'b1;
    end else if (state == ST_SYNC && uart_last) begin
      uart_load = 1'b1;
      uart_data = id_q;
    end
  end

  lin_uart_tx #(.DATA_W(BYTE_W)) u_uart (
    .clk   (clk),
    .rst   (rst),
    .abort (!active),
    .load  (uart_load && active),
    .data  (uart_data),
    .tick  (baud_tick),
    .txd   (uart_txd),
    .last  (uart_last)
  );

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (start_ok)      state <= ST_BRK;
        ST_BRK:   if (brk_underflow) state <= ST_DELIM;
        ST_DELIM: if (baud_tick)     state <= ST_SYNC;
        ST_SYNC:  if (uart_last)     state <= ST_ID;
        ST_ID:    if (uart_last)     state <= ST_IDLE;
        default:                     state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q     <= '0;
      hdr_done <= 1'b0;
      brk_flag <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      if (start_ok) id_q <= id_byte;
      hdr_done <= active && (state == ST_ID) && uart_last;
      if (brk_underflow)      brk_flag <= 1'b1;
      else if (flag_clr)      brk_flag <= 1'b0;
      if (brk_underflow && irq_en) irq_req <= 1'b1;
      else if (irq_ack)            irq_req <= 1'b0;
    end
  end

  assign tx = (state == ST_BRK) ? 1'b0 : uart_txd;
endmodule

// File: rtl/lin_hdr_checker.sv
module lin_hdr_checker (
  input logic clk,
  input logic rst,
  input logic lin_en,
  input logic master,
  input logic irq_en,
  input logic flag_clr,
  input logic irq_ack,
  input logic brk_underflow,
  input logic tx,
  input logic brk_flag,
  input logic irq_req,
  input logic hdr_done
);
  assert_brk_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_flag) |-> (tx && !$past(tx)));

  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(brk_underflow && irq_en));

  assert_irq_set_R3: assert property (@(posedge clk) disable iff (rst)
    (brk_underflow && irq_en) |=> irq_req);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    hdr_done |=> !hdr_done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    hdr_done |-> tx);

  assert_off_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !(lin_en && master) |=> (tx && !hdr_done));

  assert_flag_clr_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !brk_underflow) |=> !brk_flag);

  assert_irq_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !(brk_underflow && irq_en)) |=> !irq_req);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (tx && !brk_flag && !irq_req && !hdr_done));
endmodule

bind lin_hdr_master lin_hdr_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .lin_en        (lin_en),
  .master        (master),
  .irq_en        (irq_en),
  .flag_clr      (flag_clr),
  .irq_ack       (irq_ack),
  .brk_underflow (brk_underflow),
  .tx            (tx),
  .brk_flag      (brk_flag),
  .irq_req       (irq_req),
  .hdr_done      (hdr_done)
);

// File: tb/lin_hdr_master_bench.sv
module lin_hdr_master_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lin_en = 1'b1, master = 1'b1, irq_en = 1'b0;
  logic       start_wr = 1'b0, flag_clr = 1'b0, irq_ack = 1'b0;
  logic [7:0] brk_reload = '0, id_byte = '0;
  logic       baud_tick = 1'b0;
  logic       tx, brk_flag, irq_req, hdr_done;

  int checks = 0, fails = 0;
  bit cap = 1'b0;
  int nsamp = 0, ndone = 0;
  logic samp [0:127];
  logic fsamp [0:127];
  logic expv [0:127];

  always #10 clk = ~clk;

  lin_hdr_master u_lin_hdr_master (
    .clk(clk), .rst(rst), .lin_en(lin_en), .master(master), .irq_en(irq_en),
    .start_wr(start_wr), .brk_reload(brk_reload), .id_byte(id_byte),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .baud_tick(baud_tick),
    .tx(tx), .brk_flag(brk_flag), .irq_req(irq_req), .hdr_done(hdr_done)
  );

  // Baud tick: one clock high every four clocks, driven after the edge.
  initial begin
    forever begin
      repeat (3) begin @(posedge clk); #1 baud_tick = 1'b0; end
      @(posedge clk); #1 baud_tick = 1'b1;
    end
  end

  // Monitor: the tx value seen on a tick cycle is the bit that the tick ends.
  initial begin
    forever begin
      @(negedge clk);
      if (cap) begin
        if (baud_tick && ndone == 0 && nsamp < 128) begin
          samp[nsamp]  = tx;
          fsamp[nsamp] = brk_flag;
          nsamp++;
        end
        if (hdr_done) ndone++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_wr = 1'b1;
    @(posedge clk); #1 start_wr = 1'b0;
  endtask

  task automatic build_expect(input int n, input logic [7:0] id);
    int k = 0;
    for (int i = 0; i <= n; i++) begin expv[k] = 1'b0; k++; end
    expv[k] = 1'b1; k++;
    expv[k] = 1'b0; k++;
    for (int i = 0; i < 8; i++) begin expv[k] = 8'h55 >> i; k++; end
    expv[k] = 1'b1; k++;
    expv[k] = 1'b0; k++;
    for (int i = 0; i < 8; i++) begin expv[k] = id[i]; k++; end
    expv[k] = 1'b1;
  endtask

  task automatic run_header(input int n, input logic [7:0] id, input bit ie,
                            input bit restart, input bit chk_flag, input string req);
    int bad = -1;
    irq_en = ie; brk_reload = 8'(n); id_byte = id;
    nsamp = 0; ndone = 0;
    pulse_start();
    cap = 1'b1;
    #1 id_byte = ~id;
    if (restart) begin
      repeat (5) @(posedge clk);
      #1 brk_reload = 8'(n + 7); start_wr = 1'b1;
      @(posedge clk); #1 start_wr = 1'b0;
    end
    for (int i = 0; i < 2000 && ndone == 0; i++) @(posedge clk);
    repeat (6) @(posedge clk);
    @(negedge clk);
    cap = 1'b0;
    build_expect(n, id);
    check(nsamp == n + 22, req, "header length in ticks", nsamp, n + 22);
    for (int i = 0; i < n + 22 && i < nsamp; i++)
      if (bad < 0 && samp[i] !== expv[i]) bad = i;
    check(bad < 0, "R1 R2 R4 R5", "first wrong tick index", bad, -1);
    check(ndone == 1, "R6", "hdr_done clocks", ndone, 1);
    check(tx === 1'b1, "R6", "tx idle after header", int'(tx), 1);
    check(brk_flag === 1'b1, "R2", "brk_flag after header", int'(brk_flag), 1);
    check(irq_req === ie, "R3", "irq_req after header", int'(irq_req), int'(ie));
    if (chk_flag) begin
      check(fsamp[n] === 1'b0, "R2", "flag during last break tick", int'(fsamp[n]), 0);
      check(fsamp[n+1] === 1'b1, "R2", "flag at delimiter tick", int'(fsamp[n+1]), 1);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(tx === 1'b1 && brk_flag === 1'b0 && irq_req === 1'b0 && hdr_done === 1'b0,
          "R10", "reset outputs {tx,flag,irq,done}",
          int'({tx, brk_flag, irq_req, hdr_done}), 8);
  endtask

  task automatic t_clears();
    @(posedge clk); #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
    @(negedge clk);
    check(brk_flag === 1'b0, "R9", "flag after flag_clr", int'(brk_flag), 0);
    check(irq_req === 1'b1, "R9", "irq kept by flag_clr", int'(irq_req), 1);
    @(posedge clk); #1 irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
    @(negedge clk);
    check(irq_req === 1'b0, "R9", "irq after irq_ack", int'(irq_req), 0);
  endtask

  task automatic t_disabled(input bit en_v, input bit ms_v);
    lin_en = en_v; master = ms_v; nsamp = 0; ndone = 0;
    cap = 1'b1;
    pulse_start();
    repeat (60) @(posedge clk);
    @(negedge clk);
    cap = 1'b0;
    begin
      int lows = 0;
      for (int i = 0; i < nsamp; i++) if (samp[i] !== 1'b1) lows++;
      check(lows == 0 && nsamp > 10, "R7", "low ticks while disabled", lows, 0);
    end
    check(ndone == 0, "R7", "done while disabled", ndone, 0);
    check(brk_flag === 1'b0, "R7", "flag while disabled", int'(brk_flag), 0);
    lin_en = 1'b1; master = 1'b1;
  endtask

  task automatic t_abort();
    brk_reload = 8'd20; irq_en = 1'b0; nsamp = 0; ndone = 0;
    pulse_start();
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(tx === 1'b0, "R1", "tx low mid break", int'(tx), 0);
    @(posedge clk); #1 master = 1'b0;
    @(posedge clk); #1 cap = 1'b1;
    @(negedge clk);
    check(tx === 1'b1, "R7", "tx after master drop", int'(tx), 1);
    #1 master = 1'b1;
    repeat (150) @(posedge clk);
    @(negedge clk);
    cap = 1'b0;
    begin
      int lows = 0;
      for (int i = 0; i < nsamp; i++) if (samp[i] !== 1'b1) lows++;
      check(lows == 0, "R7", "low ticks after abort", lows, 0);
    end
    check(ndone == 0, "R7", "done after abort", ndone, 0);
    check(brk_flag === 1'b0, "R7", "flag after abort", int'(brk_flag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    run_header(3, 8'hA3, 1'b1, 1'b0, 1'b1, "R1");
    t_clears();
    run_header(0, 8'h00, 1'b0, 1'b0, 1'b1, "R1");
    @(posedge clk); #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
    run_header(5, 8'hFF, 1'b1, 1'b1, 1'b1, "R8");
    @(posedge clk); #1 flag_clr = 1'b1; irq_ack = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0; irq_ack = 1'b0;
    t_disabled(1'b0, 1'b1);
    t_disabled(1'b1, 1'b0);
    t_abort();
    run_header(2, 8'h3C, 1'b0, 1'b0, 1'b1, "R5");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule